// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits after a floating-point execution unit. It decides whether the exception flags of a completed operation become an arithmetic trap. Each operation arrives as a one-cycle strobe. The strobe carries five exception flags, the number of the destination register, and a qualifier bit that selects the software-completion trap mode. The trap enables of the control register come in on a separate input.

The qualifier selects one of two behaviours. Without it, the mode is strict: every raised flag traps, the control-register enables play no part, and the sticky exception-status register is left alone. With it, every raised flag is first merged into the sticky status register. Only the flags that the control register does not mask then reach the trap path.

A taken trap does three things. It produces a one-cycle trap request, it latches a five-bit hardware exception summary, and it marks the destination register in a 64-bit register-write mask. Separately, a per-operation flag accumulator collects the raised flags. It can be cleared by command and read at any time.

Top module: `fp_trap_ctrl`

## Requirements
- R1: Every flag vector uses this bit order: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. This applies to `op_flags`, `ctl_mask` (1 = trap disabled), `exc_status`, `acc_flags` and `trap_summary`, whose bits 0..4 are INV, DZE, FOV, UNF, INE.
- R2: With `op_swc` low, a strobe whose flag vector is nonzero traps and loads `trap_summary` with the full flag vector, whatever `ctl_mask` holds.
- R3: With `op_swc` low, a strobe leaves `exc_status` unchanged.
- R4: With `op_swc` high, a strobe ORs all its flags into `exc_status`, masked or not.
- R5: With `op_swc` high, a strobe traps only if `op_flags & ~ctl_mask` is nonzero. On a trap, `trap_summary` is loaded with exactly `op_flags & ~ctl_mask`.
- R6: A trap sets bit `op_reg` of `regwr_mask` and keeps every other bit.
- R7: A strobe that does not trap (zero flags, or all raised flags masked in software-completion mode) leaves `regwr_mask` and `trap_summary` unchanged.
- R8: `trap_req` is high for exactly the one cycle after the clock edge that samples a trapping strobe. It is low in every other cycle, including cycles without a strobe.
- R9: Every strobe ORs its flags into `acc_flags`, in either mode. `acc_clr` zeroes the accumulator. When `acc_clr` and a strobe come in the same cycle, the accumulator holds only that strobe's flags.
- R10: A synchronous active-high `rst` clears `exc_status`, `regwr_mask`, `trap_summary`, `acc_flags` and `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe of a completed operation |
| op_flags | input | 5 | Exception flags raised by the operation |
| op_reg | input | 6 | Destination register number |
| op_swc | input | 1 | Software-completion qualifier |
| ctl_mask | input | 5 | Control-register trap disables, 1 = masked |
| acc_clr | input | 1 | Clear the per-operation flag accumulator |
| acc_flags | output | 5 | Per-operation flag accumulator |
| exc_status | output | 5 | Sticky exception-status register |
| trap_req | output | 1 | One-cycle arithmetic trap request |
| trap_summary | output | 5 | Hardware exception summary of the last trap |
| regwr_mask | output | 64 | Destination registers of taken traps |

## Verification
The main function is exercised with flag vectors that are zero, have a single bit set, or are dense, each run in both modes under masks that cover none, some or all of the raised flags. Zero and fully masked vectors tell a real trap apart from a spurious one. Partly masked vectors show whether the summary is filtered in one mode but not in the other. Register numbers 0 and 63, and a repeated register number, show whether the write mask sets the right bit, keeps the others and does not toggle.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;

    localparam int unsigned FLAG_W = 5;

    // Architectural flag order (bit 0 first): invalid, div-by-zero,
    // overflow, underflow, inexact.
    typedef struct packed {
        logic ine;
        logic unf;
        logic fov;
        logic dze;
        logic inv;
    } flag_t;

    // Hardware exception summary layout.
    typedef struct packed {
        logic hw_ine;
        logic hw_unf;
        logic hw_fov;
        logic hw_dze;
        logic hw_inv;
    } hwsum_t;

    typedef enum logic {
        MODE_STRICT = 1'b0,
        MODE_SWC    = 1'b1
    } trap_mode_e;

    function automatic hwsum_t flags_to_hw(input flag_t f);
        hwsum_t h;
        h.hw_inv = f.inv;
        h.hw_dze = f.dze;
        h.hw_fov = f.fov;
        h.hw_unf = f.unf;
        h.hw_ine = f.ine;
        return h;
    endfunction

    function automatic logic any_flag(input flag_t f);
        return |f;
    endfunction

endpackage

// File: rtl/fptrap_filter.sv
module fptrap_filter
    import fptrap_pkg::*;
(
    input  logic       op_valid,
    input  flag_t      flags,
    input  trap_mode_e mode,
    input  flag_t      enable_mask,
    output flag_t      trap_flags,
    output logic       take_trap
);
    flag_t filtered;

    always_comb begin
        unique case (mode)
            MODE_SWC:    filtered = flags & ~enable_mask;
            MODE_STRICT: filtered = flags;
            default:     filtered = flags;
        endcase
        trap_flags = filtered;
        take_trap  = op_valid && any_flag(filtered);
    end
endmodule

// File: rtl/fptrap_status.sv
module fptrap_status
    import fptrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  flag_t      flags,
    input  trap_mode_e mode,
    input  logic       acc_clr,
    output flag_t      status,
    output flag_t      accum
);
    flag_t status_q, accum_q;
    flag_t accum_base;

    always_comb begin
        accum_base = acc_clr ? flag_t'('0) : accum_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            accum_q  <= '0;
        end else begin
            if (op_valid && mode == MODE_SWC)
                status_q <= status_q | flags;
            if (op_valid)
                accum_q <= accum_base | flags;
            else
                accum_q <= accum_base;
        end
    end

    assign status = status_q;
    assign accum  = accum_q;
endmodule

// File: rtl/fptrap_regmask.sv
module fptrap_regmask #(
    parameter int unsigned NUM_REGS = 64,
    localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [REG_W-1:0]    set_idx,
    output logic [NUM_REGS-1:0] mask
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
        logic bit_q;
        logic hit;
        assign hit = set_en && (set_idx == REG_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (hit)
                bit_q <= 1'b1;
        end
        assign mask[g] = bit_q;
    end
endmodule

// File: rtl/fp_trap_ctrl.sv
module fp_trap_ctrl
    import fptrap_pkg::*;
#(
    parameter int unsigned NUM_REGS = 64,
    localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [4:0]          op_flags,
    input  logic [REG_W-1:0]    op_reg,
    input  logic                op_swc,
    input  logic [4:0]          ctl_mask,
    input  logic                acc_clr,
    output logic [4:0]          acc_flags,
    output logic [4:0]          exc_status,
    output logic                trap_req,
    output logic [4:0]          trap_summary,
    output logic [NUM_REGS-1:0] regwr_mask
);
    trap_mode_e mode;
    flag_t      trap_flags;
    logic       take_trap;
    flag_t      status_w, accum_w;
    logic       trap_q;
    hwsum_t     summary_q;

    assign mode = op_swc ? MODE_SWC : MODE_STRICT;

    fptrap_filter u_filter (
        .op_valid    (op_valid),
        .flags       (flag_t'(op_flags)),
        .mode        (mode),
        .enable_mask (flag_t'(ctl_mask)),
        .trap_flags  (trap_flags),
        .take_trap   (take_trap)
    );

    fptrap_status u_status (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .flags    (flag_t'(op_flags)),
        .mode     (mode),
        .acc_clr  (acc_clr),
        .status   (status_w),
        .accum    (accum_w)
    );

    fptrap_regmask #(.NUM_REGS(NUM_REGS)) u_regmask (
        .clk     (clk),
        .rst     (rst),
        .set_en  (take_trap),
        .set_idx (op_reg),
        .mask    (regwr_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q    <= 1'b0;
            summary_q <= '0;
        end else begin
            trap_q <= take_trap;
            if (take_trap)
                summary_q <= flags_to_hw(trap_flags);
        end
    end

    assign trap_req     = trap_q;
    assign trap_summary = summary_q;
    assign exc_status   = status_w;
    assign acc_flags    = accum_w;
endmodule

// File: rtl/fptrap_checker.sv
module fptrap_checker #(
    parameter int unsigned NUM_REGS = 64,
    localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                op_valid,
    input logic [4:0]          op_flags,
    input logic [REG_W-1:0]    op_reg,
    input logic                op_swc,
    input logic [4:0]          ctl_mask,
    input logic [4:0]          exc_status,
    input logic                trap_req,
    input logic [4:0]          trap_summary,
    input logic [NUM_REGS-1:0] regwr_mask
);
    AST_NO_TRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_flags == 5'd0) |=> !trap_req); // R7
    AST_TRAP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !trap_req); // R8
    AST_STRICT_STATUS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_swc) |=> $stable(exc_status)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((exc_status & $past(exc_status)) == $past(exc_status))); // R4
    AST_MASK_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((regwr_mask & $past(regwr_mask)) == $past(regwr_mask))); // R6
    AST_MASK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(regwr_mask ^ $past(regwr_mask)) <= 1)); // R6
    AST_SUMMARY_HELD: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> $stable(trap_summary)); // R7
    AST_SUMMARY_NONZERO: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_summary != 5'd0)); // R2
    AST_SWC_MASKED_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_swc && ((op_flags & ~ctl_mask) == 5'd0)) |=> !trap_req); // R5
endmodule

bind fp_trap_ctrl fptrap_checker #(.NUM_REGS(NUM_REGS)) u_fptrap_checker (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_flags     (op_flags),
    .op_reg       (op_reg),
    .op_swc       (op_swc),
    .ctl_mask     (ctl_mask),
    .exc_status   (exc_status),
    .trap_req     (trap_req),
    .trap_summary (trap_summary),
    .regwr_mask   (regwr_mask)
);

// File: tb/test_fp_trap_ctrl.sv
`timescale 1ns/1ps
module test_fp_trap_ctrl;
    localparam int NREG = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            op_valid;
    logic [4:0]      op_flags;
    logic [5:0]      op_reg;
    logic            op_swc;
    logic [4:0]      ctl_mask;
    logic            acc_clr;
    logic [4:0]      acc_flags;
    logic [4:0]      exc_status;
    logic            trap_req;
    logic [4:0]      trap_summary;
    logic [NREG-1:0] regwr_mask;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [4:0]      m_status, m_acc, m_sum;
    logic [NREG-1:0] m_mask;

    always #4 clk = ~clk;

    fp_trap_ctrl #(.NUM_REGS(NREG)) i_fp_trap_ctrl (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
        .op_reg(op_reg), .op_swc(op_swc), .ctl_mask(ctl_mask),
        .acc_clr(acc_clr), .acc_flags(acc_flags), .exc_status(exc_status),
        .trap_req(trap_req), .trap_summary(trap_summary),
        .regwr_mask(regwr_mask)
    );

    function automatic logic [4:0] exp_trap_vec(input logic [4:0] f,
                                                input logic swc,
                                                input logic [4:0] m);
        return swc ? (f & ~m) : f;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic exp_trap, input string req);
        check({req, " trap_req"}, 64'(trap_req), 64'(exp_trap));
        check({req, " summary"}, 64'(trap_summary), 64'(m_sum));
        check({req, " status"}, 64'(exc_status), 64'(m_status));
        check({req, " regwr_mask"}, regwr_mask, m_mask);
        check({req, " acc"}, 64'(acc_flags), 64'(m_acc));
    endtask

    // Drive one strobe at a falling edge, check after the next rising edge.
    task automatic do_op(input logic [4:0] f, input logic [5:0] r,
                         input logic swc, input logic [4:0] m,
                         input logic clr, input string req);
        logic [4:0] tv;
        op_valid = 1'b1; op_flags = f; op_reg = r; op_swc = swc;
        ctl_mask = m; acc_clr = clr;
        tv = exp_trap_vec(f, swc, m);
        if (swc) m_status = m_status | f;
        m_acc = (clr ? 5'd0 : m_acc) | f;
        if (tv != 0) begin
            m_sum = tv;
            m_mask[r] = 1'b1;
        end
        @(negedge clk);
        op_valid = 1'b0; acc_clr = 1'b0;
        check_all(tv != 0, req);
    endtask

    task automatic idle(input logic clr, input logic [4:0] m, input string req);
        op_valid = 1'b0; acc_clr = clr; ctl_mask = m;
        op_flags = 5'h1f;
        if (clr) m_acc = 5'd0;
        @(negedge clk);
        acc_clr = 1'b0;
        check_all(1'b0, req);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; op_valid = 1'b0; op_flags = '0; op_reg = '0;
        op_swc = 1'b0; ctl_mask = '0; acc_clr = 1'b0;
        m_status = '0; m_acc = '0; m_sum = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        check_all(1'b0, "R10 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_all(1'b0, "R10 after reset");

        // Directed corner cases
        do_op(5'b00000, 6'd5,  1'b0, 5'b00000, 1'b0, "R7 zero flags strict");
        do_op(5'b00001, 6'd0,  1'b0, 5'b11111, 1'b0, "R2 R6 invalid reg0 mask ignored");
        do_op(5'b10000, 6'd63, 1'b0, 5'b11111, 1'b0, "R1 R3 inexact reg63");
        idle(1'b0, 5'b00000, "R8 idle cycle no trap");
        do_op(5'b00100, 6'd9,  1'b1, 5'b00100, 1'b0, "R4 R7 fully masked swc");
        do_op(5'b01110, 6'd9,  1'b1, 5'b00100, 1'b0, "R5 partly masked swc");
        do_op(5'b00010, 6'd9,  1'b1, 5'b00000, 1'b0, "R6 repeated register");
        do_op(5'b01000, 6'd20, 1'b1, 5'b10111, 1'b1, "R9 clear with strobe");
        idle(1'b1, 5'b00000, "R9 clear alone");
        do_op(5'b11111, 6'd33, 1'b0, 5'b11111, 1'b0, "R2 all flags strict");
        do_op(5'b11111, 6'd34, 1'b1, 5'b11111, 1'b0, "R4 R5 all masked swc");
        idle(1'b0, 5'b00000, "R8 pulse ends");

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [4:0] f, m;
            logic [5:0] r;
            logic       s, c;
            int         pick;
            pick = int'($urandom_range(0, 3));
            case (pick)
                0: f = 5'd0;
                1: f = 5'd1 << $urandom_range(0, 4);
                default: f = 5'($urandom);
            endcase
            m = 5'($urandom);
            r = 6'($urandom);
            s = 1'($urandom);
            c = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0)
                idle(c, m, "R8 R9 random idle");
            else
                do_op(f, r, s, m, c, s ? "R4 R5 R6 random swc" : "R2 R3 R6 random strict");
        end

        // Reset again after activity
        rst = 1'b1;
        m_status = '0; m_acc = '0; m_sum = '0; m_mask = '0;
        @(negedge clk);
        check_all(1'b0, "R10 reset after activity");
        rst = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule